// File: doc/BRIEF.md
# Eight-Channel Audio Gain Stage with Soft Mute and Pair Replication

This block sits in front of an audio DAC datapath. It handles eight signed sample channels, grouped as four stereo pairs (channels 0/1, 2/3, 4/5 and 6/7). All channels share one valid strobe. Each channel has a 10-bit linear volume code, which scales its samples in 1024 equal steps.

Each channel also has its own mute bit. Mute does not cut the signal at once. It halves the channel gain on every valid sample until the gain reaches zero, so the output stays free of clicks. Clearing mute reverses the ramp one step per sample until the gain is back at the programmed volume.

In replicate mode, every even channel takes pair 0's left input and every odd channel takes pair 0's right input. The inputs of the other pairs are then ignored. A digital power-down forces every output to zero and leaves every channel fully muted. Results appear two clock cycles after the input strobe.

Top module: `dac_gain_stage`

## Requirements
- R1: For channel c, the input sample is `in_data[c*SAMPLE_W +: SAMPLE_W]` (two's complement) and the volume code v is `vol_code[c*10 +: 10]`. When the channel is not ramped, its output is floor(x*(v+1)/1024), computed on the full-precision product.
- R2: Volume code 1023 is unity gain: the output equals the input sample exactly.
- R3: Volume code 0 gives floor(x/1024). This is the strongest attenuation short of mute.
- R4: Each channel uses only its own volume code, mute bit (`mute[c]`) and ramp state. Settings on one channel never change another channel's output.
- R5: Each channel keeps an attenuation shift s, from 0 to 11. The gain applied to a sample is (v+1)>>s, taken before the sample updates s. While the channel's mute bit is 1, each valid sample raises s by one, up to 11, where the gain is zero. With no valid strobe, s does not change.
- R6: While the mute bit is 0, each valid sample lowers s by one, down to 0. The gain therefore climbs back by doublings to the programmed volume.
- R7: With `replicate` = 1, channel c takes its sample from input channel c mod 2. The inputs of channels 2 to 7 have no effect on any output. Volume and mute remain per channel.
- R8: A sample accepted while `pwr_down` = 1 produces an output of zero. While `pwr_down` is 1, every channel's shift is held at 11. After release, an unmuted channel ramps up as in R6.
- R9: `out_valid` equals `in_valid` delayed by exactly two clock cycles. `out_data` changes only when `out_valid` is 1, and holds its value otherwise.
- R10: After reset, `out_valid` is 0, `out_data` is 0, and every channel's shift is 0 (full volume).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe shared by all channels |
| in_data | input | 8*SAMPLE_W | Eight packed signed samples, channel 0 in the low bits |
| vol_code | input | 80 | Eight packed 10-bit volume codes |
| mute | input | 8 | Soft-mute request, one bit per channel |
| replicate | input | 1 | Drive all pairs from pair 0 |
| pwr_down | input | 1 | Digital power-down |
| out_valid | output | 1 | Output strobe, two cycles after in_valid |
| out_data | output | 8*SAMPLE_W | Eight packed scaled samples |

## Verification
The shift of a channel is hidden state. If it is wrong, the fault shows at the ports on the very next valid sample, as an output off by a factor of two or more. A shift that sticks or jumps also breaks the doubling sequence within a few strobes of a mute change. Because of that, the bench follows the shift for every channel from the requirements and compares all eight outputs on every strobe. A wrong source selection in replicate mode, or a leak between channels, shows up on the first sample whose channels carry distinct data.

// File: rtl/dgs_pkg.sv
package dgs_pkg;

  // Direction taken by a channel's attenuation ramp in one cycle
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_DOWN = 2'd1,
    RAMP_UP   = 2'd2,
    RAMP_PARK = 2'd3
  } ramp_dir_e;

endpackage

// File: rtl/dgs_ramp.sv
module dgs_ramp
  import dgs_pkg::*;
#(
  parameter int SHIFT_MAX = 11,
  localparam int SH_W = $clog2(SHIFT_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            mute_req,
  input  logic            pd,
  output logic [SH_W-1:0] shift
);

  localparam logic [SH_W-1:0] SH_TOP = SH_W'(SHIFT_MAX);

  ramp_dir_e       dir;
  logic [SH_W-1:0] shift_q;
  logic [SH_W-1:0] shift_d;

  always_comb begin
    dir = RAMP_HOLD;
    if (pd)
      dir = RAMP_PARK;
    else if (adv && mute_req && shift_q != SH_TOP)
      dir = RAMP_DOWN;
    else if (adv && !mute_req && shift_q != '0)
      dir = RAMP_UP;
  end

  always_comb begin
    case (dir)
      RAMP_PARK: shift_d = SH_TOP;
      RAMP_DOWN: shift_d = shift_q + 1'b1;
      RAMP_UP:   shift_d = shift_q - 1'b1;
      default:   shift_d = shift_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shift_q <= '0;
    else
      shift_q <= shift_d;
  end

  assign shift = shift_q;

  // R5 R6: outside power-down the shift moves by at most one step
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !pd |=> (shift_q == $past(shift_q) || shift_q == $past(shift_q) + 1'b1 ||
             shift_q + 1'b1 == $past(shift_q)));

  // R5: without a strobe or power-down the ramp holds
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !pd) |=> $stable(shift_q));

  // R8: power-down parks the ramp at fully muted
  a_r8_park_muted: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> shift_q == SH_TOP);

  a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    shift_q <= SH_TOP);

endmodule

// File: rtl/dgs_chan.sv
module dgs_chan #(
  parameter int SAMPLE_W = 24,
  parameter int VOL_W    = 10,
  localparam int GAIN_W  = VOL_W + 1,
  localparam int SH_W    = $clog2(VOL_W + 2),
  localparam int PROD_W  = SAMPLE_W + GAIN_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vld_s0,
  input  logic                vld_s1,
  input  logic                pd,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic [VOL_W-1:0]    vol,
  input  logic [SH_W-1:0]     shift,
  output logic [SAMPLE_W-1:0] dout
);

  logic [GAIN_W-1:0]          gain_full;
  logic [GAIN_W-1:0]          gain_d;
  logic [GAIN_W-1:0]          gain_q;
  logic [SAMPLE_W-1:0]        smp_q;
  logic signed [PROD_W-1:0]   prod;
  logic [SAMPLE_W-1:0]        dout_d;
  logic [SAMPLE_W-1:0]        dout_q;

  always_comb begin
    gain_full = {1'b0, vol} + 1'b1;
    gain_d    = pd ? '0 : (gain_full >> shift);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= '0;
      gain_q <= '0;
    end else if (vld_s0) begin
      smp_q  <= smp;
      gain_q <= gain_d;
    end
  end

  always_comb begin
    prod   = PROD_W'($signed(smp_q)) * $signed({1'b0, gain_q});
    dout_d = prod[VOL_W +: SAMPLE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dout_q <= '0;
    else if (vld_s1)
      dout_q <= dout_d;
  end

  assign dout = dout_q;

  // R8: a sample taken during power-down leaves a zero output
  a_r8_pd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vld_s0 && pd, 2) |-> dout_q == '0);

  // R9: output register holds between strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vld_s1) |-> $stable(dout_q));

  // R1: gain never exceeds unity
  a_r1_gain_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= GAIN_W'(1 << VOL_W));

endmodule

// File: rtl/dac_gain_stage.sv
module dac_gain_stage #(
  parameter int CH_PAIRS = 4,
  parameter int SAMPLE_W = 24,
  parameter int VOL_W    = 10,
  localparam int NCH     = 2 * CH_PAIRS,
  localparam int SH_MAX  = VOL_W + 1,
  localparam int SH_W    = $clog2(SH_MAX + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [NCH*SAMPLE_W-1:0] in_data,
  input  logic [NCH*VOL_W-1:0]    vol_code,
  input  logic [NCH-1:0]          mute,
  input  logic                    replicate,
  input  logic                    pwr_down,
  output logic                    out_valid,
  output logic [NCH*SAMPLE_W-1:0] out_data
);

  logic vld_s1_q;
  logic vld_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_s1_q <= 1'b0;
      vld_s2_q <= 1'b0;
    end else begin
      vld_s1_q <= in_valid;
      vld_s2_q <= vld_s1_q;
    end
  end

  assign out_valid = vld_s2_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SH_W-1:0]     shift;
    logic [SAMPLE_W-1:0] src;

    always_comb
      src = replicate ? in_data[(c % 2)*SAMPLE_W +: SAMPLE_W]
                      : in_data[c*SAMPLE_W +: SAMPLE_W];

    dgs_ramp #(.SHIFT_MAX(SH_MAX)) u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (in_valid),
      .mute_req (mute[c]),
      .pd       (pwr_down),
      .shift    (shift)
    );

    dgs_chan #(.SAMPLE_W(SAMPLE_W), .VOL_W(VOL_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_s0 (in_valid),
      .vld_s1 (vld_s1_q),
      .pd     (pwr_down),
      .smp    (src),
      .vol    (vol_code[c*VOL_W +: VOL_W]),
      .shift  (shift),
      .dout   (out_data[c*SAMPLE_W +: SAMPLE_W])
    );
  end

  // R9: fixed two-cycle strobe latency
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 2));

endmodule

// File: tb/dac_gain_stage_bench.sv
`timescale 1ns/1ps
module dac_gain_stage_bench;

  localparam int W   = 16;
  localparam int NCH = 8;

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic [NCH*W-1:0]   in_data;
  logic [NCH*10-1:0]  vol_code;
  logic [NCH-1:0]     mute;
  logic               replicate;
  logic               pwr_down;
  logic               out_valid;
  logic [NCH*W-1:0]   out_data;

  int compared;
  int mismatched;
  int sh [NCH];
  logic [W-1:0] last_exp [NCH];

  dac_gain_stage #(.CH_PAIRS(4), .SAMPLE_W(W), .VOL_W(10)) u_dac_gain_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .vol_code(vol_code), .mute(mute), .replicate(replicate),
    .pwr_down(pwr_down), .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string tag, int ch, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s ch%0d: actual %0d expected %0d", tag, ch,
               $signed(act), $signed(exp));
    end
  endtask

  // Send one strobe and compare all channels two cycles later
  task automatic send(string tag);
    logic [W-1:0] exp [NCH];
    for (int c = 0; c < NCH; c++) begin
      longint x;
      longint g;
      longint p;
      x = longint'($signed(replicate ? in_data[(c % 2)*W +: W] : in_data[c*W +: W]));
      g = pwr_down ? 0 : ((longint'(vol_code[c*10 +: 10]) + 1) >> sh[c]);
      p = (x * g) >>> 10;
      exp[c] = W'(p);
      if (pwr_down) sh[c] = 11;
      else if (mute[c]) sh[c] = (sh[c] < 11) ? sh[c] + 1 : 11;
      else sh[c] = (sh[c] > 0) ? sh[c] - 1 : 0;
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R9 strobe early"}, -1, W'(out_valid), W'(0));
    @(negedge clk);
    check({tag, " R9 strobe"}, -1, W'(out_valid), W'(1));
    for (int c = 0; c < NCH; c++) begin
      check(tag, c, out_data[c*W +: W], exp[c]);
      last_exp[c] = exp[c];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    compared = 0; mismatched = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; vol_code = '1;
    mute = '0; replicate = 1'b0; pwr_down = 1'b0;
    for (int c = 0; c < NCH; c++) sh[c] = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 valid", -1, W'(out_valid), W'(0));
    for (int c = 0; c < NCH; c++) check("R10 data", c, out_data[c*W +: W], W'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R2: unity at code 1023, extremes and mixed samples
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < NCH; c++)
        in_data[c*W +: W] = (k == 0) ? ((c % 2) ? 16'h7FFF : 16'h8000)
                                     : W'(k * 12345 + c * 777);
      send("R2 unity");
    end

    // R1 R3 R4: every volume code, distinct per channel
    for (int k = 0; k < 128; k++) begin
      for (int c = 0; c < NCH; c++) begin
        vol_code[c*10 +: 10] = 10'((k * 8 + c * 129) % 1024);
        in_data[c*W +: W] = (k < 2) ? ((c % 2) ? 16'h7FFF : 16'h8000)
                                    : W'(k * 40503 + c * 9973);
      end
      send("R1 R4 volume sweep");
    end
    for (int c = 0; c < NCH; c++) begin
      vol_code[c*10 +: 10] = 10'd0;
      in_data[c*W +: W] = W'(-1000 + c * 700);
    end
    send("R3 code zero");

    // R9: hold between strobes while inputs change
    in_data = '1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++)
      check("R9 hold", c, out_data[c*W +: W], last_exp[c]);

    // R5 R6: mute ramp on channel 3 only, then unmute
    vol_code = '1;
    for (int c = 0; c < NCH; c++) in_data[c*W +: W] = W'(20000 - c * 5000);
    mute = 8'b0000_1000;
    for (int k = 0; k < 13; k++) send("R5 mute ramp");
    // R5: idle cycles do not move the ramp
    repeat (4) @(negedge clk);
    mute = 8'b0000_0000;
    for (int k = 0; k < 13; k++) send("R6 unmute ramp");

    // R7: replicate, distinct data on all inputs
    replicate = 1'b1;
    for (int k = 0; k < 20; k++) begin
      for (int c = 0; c < NCH; c++) begin
        in_data[c*W +: W] = W'(k * 3001 + c * 4099 - 9000);
        vol_code[c*10 +: 10] = 10'((c * 131 + k * 17) % 1024);
      end
      send("R7 replicate");
    end
    replicate = 1'b0;

    // R8: power-down zeroes outputs, then ramp back up
    mute = 8'b0100_0000;
    pwr_down = 1'b1;
    for (int k = 0; k < 3; k++) send("R8 power-down");
    pwr_down = 1'b0;
    for (int k = 0; k < 13; k++) send("R8 release ramp");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule